// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block decides when a small microcontroller is held in reset and why. It watches four reset sources: a power-on detect pulse, an external active-low master clear pin, a watchdog time-out, and a sleep flag that changes what the watchdog and master clear mean. From these it tells five causes apart. These are power-on, master clear while running, master clear while asleep, watchdog expiry while running, and watchdog expiry while asleep. A watchdog expiry while asleep is not a reset. It is a wake-up that keeps all register contents. Every other cause is a reset.

The master clear pin passes a glitch filter before it counts as a reset. For each reset, the chip-reset output rises at once. It falls only after two start-up delays have expired one after the other. The first is a power-up delay counted on a separate free-running timer clock. The second is an oscillator settling delay counted on the main clock. Either delay can be bypassed by its enable input, and any new reset source restarts both. Two status bits, time-out and power-down, record the cause so that software can read it after restart.

Top module: `rst_wake_seq`

## Requirements
- R1: The master clear pin is accepted only after it is sampled low on FILT_LEN consecutive main-clock edges. Then reg_rst_o pulses on the edge FILT_LEN+2 edges after the first edge that sees the pin low. A low pulse seen on only FILT_LEN-1 edges causes no reg_rst_o pulse and leaves to_o and pd_o unchanged.
- R2: reg_rst_o is a single-cycle pulse. It goes high one clock after a reset source first becomes active. The reset sources are por_i high, an accepted master clear, or wdt_to_i high with sleep_i low.
- R3: wdt_to_i rising while sleep_i is high gives a single-cycle wake_o pulse one clock later. It gives no reg_rst_o pulse and leaves chip_rst_o low.
- R4: Status bits {to_o,pd_o} take these values. Power-on gives 11. Watchdog while running gives 01. Watchdog while asleep gives 00. Master clear while asleep gives 10. Master clear while running leaves them unchanged. When sources arrive together, power-on wins over master clear, and master clear wins over watchdog.
- R5: chip_rst_o is high one clock after any reset source becomes active and stays high while the source remains active.
- R6: With both delays enabled, chip_rst_o falls no sooner than PWRT_TERM timer-clock periods plus OST_TERM main-clock periods after the last source goes away. It falls no later than that plus eight periods of each clock.
- R7: A bypassed delay counts as already expired. With only the settling delay enabled, chip_rst_o falls OST_TERM+1 edges after the last edge that saw a source. With both bypassed, it falls on the first edge that sees no source.
- R8: A reset source that arrives while a delay is running restarts the delays. Release is timed from the end of the newest source.
- R9: While rst_ni is low, chip_rst_o=1, to_o=1, pd_o=1, reg_rst_o=0 and wake_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock; clocks the filter, the status bits and the settling delay |
| tmr_clk_i | input | 1 | Free-running on-chip timer clock for the power-up delay |
| rst_ni | input | 1 | Synchronous active-low reset of the block's own flops |
| por_i | input | 1 | Power-on detect, active high |
| mclr_ni | input | 1 | External master clear pin, active low, unfiltered |
| wdt_to_i | input | 1 | Watchdog time-out, active high |
| sleep_i | input | 1 | High while the core is in sleep mode |
| pwrt_en_i | input | 1 | Enables the power-up delay; low bypasses it |
| ost_en_i | input | 1 | Enables the oscillator settling delay; low bypasses it |
| chip_rst_o | output | 1 | Holds the chip in reset |
| reg_rst_o | output | 1 | One-cycle strobe that returns registers to their reset values |
| wake_o | output | 1 | One-cycle strobe for a watchdog wake-up from sleep |
| to_o | output | 1 | Time-out status bit |
| pd_o | output | 1 | Power-down status bit |

## Verification
reg_rst_o, wake_o, the status bits and the rise of chip_rst_o are all due one clock after the edge that first sees their cause. The exception is master clear, which adds the two synchronizer flops and FILT_LEN filter edges. The release of chip_rst_o is due a fixed OST_TERM+1 edges after the source ends when only the settling delay is used. The bench schedules each expected value for its exact cycle by counting main-clock edges from the stimulus. It samples on the falling edge. The power-up delay crosses clock domains, so its release gets a time window checked in nanoseconds instead of an exact cycle.

// File: rtl/rws_pkg.sv
// Package rws_pkg
// Shared cause encoding and status update rule for the reset sequencer.
// Assumes status bits are held as {to, pd}.
package rws_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_POR,
        CAUSE_MCLR_RUN,
        CAUSE_MCLR_SLEEP,
        CAUSE_WDT_RUN,
        CAUSE_WDT_SLEEP
    } rws_cause_e;

    // Next {to, pd} for a given cause; unchanged for no cause or run-mode clear.
    function automatic logic [1:0] status_next(rws_cause_e cause, logic [1:0] cur);
        logic [1:0] nxt;
        case (cause)
            CAUSE_POR:        nxt = 2'b11;
            CAUSE_WDT_RUN:    nxt = 2'b01;
            CAUSE_WDT_SLEEP:  nxt = 2'b00;
            CAUSE_MCLR_SLEEP: nxt = 2'b10;
            default:          nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/rws_sync.sv
// Module rws_sync
// Multi-stage synchronizer for W independent single-bit signals into clk_i.
// Assumes each bit is individually meaningful (no multi-bit coherence needed).
module rws_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [W-1:0] stg_q;
            // Single capture flop.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stg_q <= RST_VAL;
                else         stg_q <= d_i;
            end
            assign q_o = stg_q;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] stg_q;
            // Shift the input through the flop chain.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
                else         stg_q <= {stg_q[STAGES-2:0], d_i};
            end
            assign q_o = stg_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rws_pin_filter.sv
// Module rws_pin_filter
// Synchronizes an active-low pin and accepts it only after LEN consecutive
// low samples. Assumes LEN >= 1; act_o drops on the first high sample.
module rws_pin_filter #(
    parameter int LEN = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_ni,
    output logic act_o
);

    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LEN_V = CW'(LEN);

    logic          pin_s;
    logic [CW-1:0] run_q;

    rws_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_pin_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_ni),
        .q_o    (pin_s)
    );

    // Count consecutive low samples, saturating at LEN.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)             run_q <= '0;
        else if (pin_s)          run_q <= '0;
        else if (run_q != LEN_V) run_q <= run_q + 1'b1;
    end

    assign act_o = (run_q == LEN_V);

    AST_FILT_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(act_o) |-> !$past(pin_s)); // R1

endmodule

// File: rtl/rws_term_counter.sv
// Module rws_term_counter
// Up-counter that clears on clr_i, counts while en_i, and stops at TERM.
// Assumes 1 <= TERM <= 2**W-1; done_o is high while the count equals TERM.
module rws_term_counter #(
    parameter int W    = 10,
    parameter int TERM = 1023
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic en_i,
    output logic done_o
);

    localparam logic [W-1:0] TERM_V = W'(TERM);

    logic [W-1:0] cnt_q;

    // Clear, advance or hold the count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i)   cnt_q <= '0;
        else if (en_i && !done_o) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (cnt_q == TERM_V);

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= TERM_V); // R6
    AST_CNT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !done_o); // R8

endmodule

// File: rtl/rst_wake_seq.sv
// Module rst_wake_seq
// Reset controller: filters master clear, classifies the cause, updates the
// time-out/power-down status bits, and sequences a power-up delay (timer
// clock) followed by a settling delay (main clock) before releasing chip reset.
// Assumes por_i, wdt_to_i, sleep_i and the enables are synchronous to clk_i and
// that tmr_clk_i runs freely whenever rst_ni is released.
module rst_wake_seq #(
    parameter int FILT_LEN  = 4,
    parameter int CNT_W     = 10,
    parameter int PWRT_TERM = 1023,
    parameter int OST_TERM  = 1023
) (
    input  logic clk_i,
    input  logic tmr_clk_i,
    input  logic rst_ni,
    input  logic por_i,
    input  logic mclr_ni,
    input  logic wdt_to_i,
    input  logic sleep_i,
    input  logic pwrt_en_i,
    input  logic ost_en_i,
    output logic chip_rst_o,
    output logic reg_rst_o,
    output logic wake_o,
    output logic to_o,
    output logic pd_o
);

    import rws_pkg::*;

    // ---------------- source detection and classification ----------------
    logic       mclr_act;
    logic       src_act, src_q, src_rise;
    logic       wk_cause, wk_q, wk_rise;
    rws_cause_e cause_now;
    logic [1:0] stat_q;

    rws_pin_filter #(.LEN(FILT_LEN)) u_mclr_filt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_ni (mclr_ni),
        .act_o  (mclr_act)
    );

    assign src_act  = por_i | mclr_act | (wdt_to_i & ~sleep_i);
    assign src_rise = src_act & ~src_q;
    assign wk_cause = wdt_to_i & sleep_i & ~src_act;
    assign wk_rise  = wk_cause & ~wk_q;

    // Pick the cause for this cycle by priority: power-on, clear, watchdog.
    always_comb begin
        cause_now = CAUSE_NONE;
        if (src_rise) begin
            if (por_i)         cause_now = CAUSE_POR;
            else if (mclr_act) cause_now = sleep_i ? CAUSE_MCLR_SLEEP : CAUSE_MCLR_RUN;
            else               cause_now = CAUSE_WDT_RUN;
        end else if (wk_rise) begin
            cause_now = CAUSE_WDT_SLEEP;
        end
    end

    // Edge history, strobes and status bits.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            src_q     <= 1'b0;
            wk_q      <= 1'b0;
            reg_rst_o <= 1'b0;
            wake_o    <= 1'b0;
            stat_q    <= 2'b11;
        end else begin
            src_q     <= src_act;
            wk_q      <= wk_cause;
            reg_rst_o <= src_rise;
            wake_o    <= wk_rise;
            stat_q    <= status_next(cause_now, stat_q);
        end
    end

    assign to_o = stat_q[1];
    assign pd_o = stat_q[0];

    // ---------------- power-up delay, timer clock domain ----------------
    logic clr_hold_q;
    logic clr_t, pwrt_done_t;
    logic ack_s, pwrt_done_s;
    logic pwrt_ok;

    // Request a clear of the power-up delay until the timer domain confirms it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      clr_hold_q <= 1'b1;
        else if (src_act) clr_hold_q <= 1'b1;
        else if (ack_s)   clr_hold_q <= 1'b0;
    end

    rws_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_clr_to_tmr (
        .clk_i  (tmr_clk_i),
        .rst_ni (rst_ni),
        .d_i    (clr_hold_q),
        .q_o    (clr_t)
    );

    rws_term_counter #(.W(CNT_W), .TERM(PWRT_TERM)) u_pwrt_cnt (
        .clk_i  (tmr_clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_t),
        .en_i   (1'b1),
        .done_o (pwrt_done_t)
    );

    rws_sync #(.W(2), .STAGES(2), .RST_VAL(2'b10)) u_tmr_to_sys (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({clr_t, pwrt_done_t}),
        .q_o    ({ack_s, pwrt_done_s})
    );

    assign pwrt_ok = ~pwrt_en_i | (pwrt_done_s & ~clr_hold_q & ~ack_s);

    // ---------------- settling delay, main clock domain ----------------
    logic ost_done, ost_ok, time_out;

    rws_term_counter #(.W(CNT_W), .TERM(OST_TERM)) u_ost_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (src_act),
        .en_i   (pwrt_ok & ost_en_i),
        .done_o (ost_done)
    );

    assign ost_ok   = ~ost_en_i | ost_done;
    assign time_out = pwrt_ok & ost_ok & ~src_act;

    // Set/clear latch: any source sets, completed time-out clears.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)       chip_rst_o <= 1'b1;
        else if (src_act)  chip_rst_o <= 1'b1;
        else if (time_out) chip_rst_o <= 1'b0;
    end

    // ---------------- assertions ----------------
    AST_REGRST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rst_o |=> !reg_rst_o); // R2
    AST_WAKE_KEEPS_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> !reg_rst_o); // R3
    AST_WAKE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> (!to_o && !pd_o)); // R4
    AST_RST_FOLLOWS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_act |=> chip_rst_o); // R5
    AST_RELEASE_AFTER_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(chip_rst_o) |-> !$past(src_act)); // R6

endmodule

// File: tb/rst_wake_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: stimulus tasks queue expected output values at exact
// main-clock cycles; a falling-edge monitor pops and compares them.
module rst_wake_seq_bench;

    localparam int FILT = 4;
    localparam int PT   = 8;
    localparam int OT   = 16;
    localparam int SYS_NS  = 20;
    localparam int TMR_NS  = 70;

    logic clk = 1'b0, tclk = 1'b0;
    logic rst_n = 1'b0, por = 1'b0, mclr_n = 1'b1, wdt = 1'b0, sleep = 1'b0;
    logic pwrt_en = 1'b1, ost_en = 1'b1;
    logic chip_rst, reg_rst, wake, to_b, pd_b;

    always #(SYS_NS/2) clk = ~clk;
    always #(TMR_NS/2) tclk = ~tclk;

    rst_wake_seq #(.FILT_LEN(FILT), .CNT_W(10), .PWRT_TERM(PT), .OST_TERM(OT)) u_rst_wake_seq (
        .clk_i(clk), .tmr_clk_i(tclk), .rst_ni(rst_n), .por_i(por), .mclr_ni(mclr_n),
        .wdt_to_i(wdt), .sleep_i(sleep), .pwrt_en_i(pwrt_en), .ost_en_i(ost_en),
        .chip_rst_o(chip_rst), .reg_rst_o(reg_rst), .wake_o(wake), .to_o(to_b), .pd_o(pd_b)
    );

    typedef struct {int due; int sig; logic val; string req;} exp_t;
    exp_t exp_q[$];
    int cyc = 0;
    int n_chk = 0, n_err = 0;
    bit done_flag = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic sig_val(int s);
        case (s)
            0: return chip_rst;
            1: return reg_rst;
            2: return wake;
            3: return to_b;
            default: return pd_b;
        endcase
    endfunction

    function automatic string sig_name(int s);
        case (s)
            0: return "chip_rst_o";
            1: return "reg_rst_o";
            2: return "wake_o";
            3: return "to_o";
            default: return "pd_o";
        endcase
    endfunction

    task automatic expect_at(input int due, input int s, input logic v, input string req);
        exp_t e;
        e.due = due; e.sig = s; e.val = v; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic check(input logic act, input logic expv, input string what);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", what, act, expv);
        end
    endtask

    // Drive point: mid-high phase after an edge.
    task automatic step();
        @(posedge clk); #5;
    endtask

    // Monitor: compare every item due in this cycle on the falling edge.
    always @(negedge clk) begin
        for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].due == cyc) begin
                logic a;
                a = sig_val(exp_q[i].sig);
                n_chk++;
                if (a !== exp_q[i].val) begin
                    n_err++;
                    $display("FAIL %s %s cycle %0d actual=%b expected=%b",
                             exp_q[i].req, sig_name(exp_q[i].sig), cyc, a, exp_q[i].val);
                end
                exp_q.delete(i);
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(200000 * SYS_NS);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int c0, c1;
        time t0, t1, lo, hi;
        bit fell;

        // R9: state during reset
        repeat (4) @(negedge clk);
        check(chip_rst, 1'b1, "R9 chip_rst_o in reset");
        check(to_b,     1'b1, "R9 to_o in reset");
        check(pd_b,     1'b1, "R9 pd_o in reset");
        check(reg_rst,  1'b0, "R9 reg_rst_o in reset");
        check(wake,     1'b0, "R9 wake_o in reset");
        step(); rst_n = 1'b1;
        for (int k = 0; k < 400 && chip_rst; k++) step();

        // R6: both delays, release window
        step(); por = 1'b1;
        step(); por = 1'b0; t0 = $time;
        fell = 0;
        for (int k = 0; k < 400 && !fell; k++) begin
            step();
            if (!chip_rst) fell = 1;
        end
        t1 = $time;
        lo = PT * TMR_NS + OT * SYS_NS;
        hi = lo + 8 * TMR_NS + 8 * SYS_NS;
        n_chk++;
        if (!fell || (t1 - t0) < lo || (t1 - t0) > hi) begin
            n_err++;
            $display("FAIL R6 release delay actual=%0t expected=%0t..%0t", t1 - t0, lo, hi);
        end

        // R7: settling delay only, exact release
        pwrt_en = 1'b0;
        step(); c0 = cyc; por = 1'b1;
        expect_at(c0 + 1, 1, 1'b1, "R2");
        expect_at(c0 + 2, 1, 1'b0, "R2");
        expect_at(c0 + 1, 0, 1'b1, "R5");
        expect_at(c0 + 1, 3, 1'b1, "R4");
        expect_at(c0 + 1, 4, 1'b1, "R4");
        step(); por = 1'b0;
        expect_at(c0 + 1 + OT, 0, 1'b1, "R7");
        expect_at(c0 + 2 + OT, 0, 1'b0, "R7");
        repeat (OT + 4) step();

        // R8: retrigger restarts the delay
        step(); c0 = cyc; por = 1'b1;
        step(); por = 1'b0;
        repeat (5) step();
        c1 = cyc; por = 1'b1;
        expect_at(c0 + 2 + OT, 0, 1'b1, "R8");
        step(); por = 1'b0;
        expect_at(c1 + 1 + OT, 0, 1'b1, "R8");
        expect_at(c1 + 2 + OT, 0, 1'b0, "R8");
        repeat (OT + 4) step();

        // R7: both bypassed
        ost_en = 1'b0;
        step(); c0 = cyc; por = 1'b1;
        step(); por = 1'b0;
        expect_at(c0 + 1, 0, 1'b1, "R7");
        expect_at(c0 + 2, 0, 1'b0, "R7");
        repeat (3) step();

        // R4/R2: watchdog while running
        step(); c0 = cyc; wdt = 1'b1;
        step(); wdt = 1'b0;
        expect_at(c0 + 1, 1, 1'b1, "R2");
        expect_at(c0 + 1, 3, 1'b0, "R4");
        expect_at(c0 + 1, 4, 1'b1, "R4");
        expect_at(c0 + 1, 0, 1'b1, "R5");
        expect_at(c0 + 1, 2, 1'b0, "R3");
        repeat (3) step();

        // R3/R4: watchdog during sleep is a wake-up
        sleep = 1'b1;
        step(); c0 = cyc; wdt = 1'b1;
        step(); wdt = 1'b0;
        expect_at(c0 + 1, 2, 1'b1, "R3");
        expect_at(c0 + 2, 2, 1'b0, "R3");
        expect_at(c0 + 1, 1, 1'b0, "R3");
        expect_at(c0 + 1, 0, 1'b0, "R3");
        expect_at(c0 + 1, 3, 1'b0, "R4");
        expect_at(c0 + 1, 4, 1'b0, "R4");
        repeat (3) step();

        // R1: short master clear is ignored
        step(); c0 = cyc; mclr_n = 1'b0;
        for (int k = 1; k <= FILT + 5; k++) expect_at(c0 + k, 1, 1'b0, "R1");
        expect_at(c0 + FILT + 5, 0, 1'b0, "R1");
        expect_at(c0 + FILT + 5, 3, 1'b0, "R1");
        expect_at(c0 + FILT + 5, 4, 1'b0, "R1");
        repeat (FILT - 1) step();
        mclr_n = 1'b1;
        repeat (8) step();

        // R1/R4: accepted master clear during sleep
        step(); c0 = cyc; mclr_n = 1'b0;
        expect_at(c0 + FILT + 2, 1, 1'b0, "R1");
        expect_at(c0 + FILT + 3, 1, 1'b1, "R1");
        expect_at(c0 + FILT + 3, 3, 1'b1, "R4");
        expect_at(c0 + FILT + 3, 4, 1'b0, "R4");
        expect_at(c0 + FILT + 3, 0, 1'b1, "R5");
        repeat (FILT) step();
        mclr_n = 1'b1;
        repeat (8) step();

        // R4: master clear while running keeps status (set to 01 first)
        sleep = 1'b0;
        step(); wdt = 1'b1;
        step(); wdt = 1'b0;
        repeat (3) step();
        step(); c0 = cyc; mclr_n = 1'b0;
        expect_at(c0 + FILT + 3, 1, 1'b1, "R2");
        expect_at(c0 + FILT + 3, 3, 1'b0, "R4");
        expect_at(c0 + FILT + 3, 4, 1'b1, "R4");
        repeat (FILT) step();
        mclr_n = 1'b1;
        repeat (8) step();

        // R4: power-on wins over watchdog
        step(); c0 = cyc; por = 1'b1; wdt = 1'b1;
        step(); por = 1'b0; wdt = 1'b0;
        expect_at(c0 + 1, 3, 1'b1, "R4");
        expect_at(c0 + 1, 4, 1'b1, "R4");
        repeat (4) step();

        for (int k = 0; k < 50 && exp_q.size() > 0; k++) step();
        finish_run();
    end

endmodule